// File: doc/BRIEF.md
# RMII Receive Di-bit Formatter

This block is the receive side of a Reduced MII port as seen from the PHY. A receive decoder hands it 4-bit nibbles together with a carrier flag, a nibble strobe and two error flags (false carrier and symbol error). The nibbles go into a small elastic FIFO. From there they are sent out as 2-bit di-bits on `rxd`, with the combined carrier/valid signal `crs_dv`. Everything is timed by the 50 MHz reference clock.

The output runs at one di-bit per clock at 100 Mb/s, or one di-bit per ten clocks at 10 Mb/s. After carrier is detected, the output sends quiet di-bits until the first nibble is buffered. Errors are reported in-band with a fixed error code. When carrier ends while data is still buffered, `crs_dv` alternates on each nibble until the FIFO is empty. This lets the MAC recover both carrier and data-valid from one wire.

Top module: `rmii_rx_formatter`

## Requirements
- R1: During and right after synchronous reset, `crs_dv` is 0 and `rxd` is 00.
- R2: From idle, the clock edge that samples `rx_crs` high drives `crs_dv` to 1. `rxd` stays 00 for as long as the FIFO holds no nibble and no error has been flagged.
- R3: Each nibble `n` goes out as two di-bits, `n[1:0]` first and then `n[3:2]`. A buffered nibble 0101 therefore shows up first as the di-bit 01.
- R4: At 100 Mb/s (`speed_10` = 0), `rxd` and `crs_dv` may take a new value on every clock edge.
- R5: At 10 Mb/s (`speed_10` = 1), once a carrier has started, `rxd` and `crs_dv` stay unchanged for 10 consecutive clocks per di-bit.
- R6: If `rx_false` or `rx_err` is high while `rx_crs` is high, every di-bit period that starts after that edge outputs `rxd` = 10, until the block returns to idle.
- R7: During a false carrier (carrier with no nibbles), `crs_dv` stays 1 for as long as `rx_crs` stays high.
- R8: After `rx_crs` has dropped and nibbles remain, `crs_dv` is 0 on the first di-bit of each nibble and 1 on the second.
- R9: At the start of a nibble period, if the FIFO is empty and `rx_crs` is low, the block goes idle with `crs_dv` = 0 and `rxd` = 00.
- R10: `speed_10` is taken in only while the block is idle. A change during a carrier has no effect until the block is idle again.
- R11: The FIFO holds 8 nibbles. A nibble strobed while the FIFO is full is dropped, and the nibbles already held are sent out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_10 | input | 1 | 1 = 10 Mb/s pacing, 0 = 100 Mb/s |
| rx_crs | input | 1 | Carrier present from the decoder |
| rx_dv | input | 1 | Strobe: `rx_nib` holds a nibble this cycle |
| rx_nib | input | 4 | Received nibble |
| rx_false | input | 1 | False carrier flagged by the decoder |
| rx_err | input | 1 | Symbol error flagged by the decoder |
| crs_dv | output | 1 | Combined carrier sense / data valid |
| rxd | output | 2 | Received di-bit |

## Verification
The outputs are registered, so a di-bit decision is visible one clock edge after the inputs that produced it. At 100 Mb/s that is the next cycle. At 10 Mb/s the decision is taken only on the tenth clock of each di-bit period, counted from the edge that left idle. An error flag changes the output only from the next di-bit period on. The bench keeps a reference model that advances on the same edges, from the requirements alone. It compares `crs_dv` and `rxd` on every falling edge, half a period after the edge that updates them. Directed checks of carrier rise, false-carrier level and return to idle sample on the falling edge after the edge where the rule applies.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

    localparam int NIB_W   = 4;
    localparam int DIBIT_W = 2;

    typedef logic [NIB_W-1:0]   nib_t;
    typedef logic [DIBIT_W-1:0] dibit_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LIVE = 1'b1
    } rx_state_e;

    localparam dibit_t DB_QUIET = 2'b00;
    localparam dibit_t DB_BAD   = 2'b10;

    typedef struct packed {
        logic   crs_dv;
        dibit_t rxd;
    } pin_out_t;

    localparam pin_out_t PINS_REST = '{crs_dv: 1'b0, rxd: DB_QUIET};

    function automatic dibit_t nib_half(input nib_t n, input logic upper);
        return upper ? n[3:2] : n[1:0];
    endfunction

endpackage

// File: rtl/rmii_rx_fifo.sv
module rmii_rx_fifo
    import rmii_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  nib_t din,
    output nib_t dout,
    output logic empty,
    output logic full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    nib_t          store [DEPTH];
    logic [AW:0]   wr_ptr;
    logic [AW:0]   rd_ptr;
    logic          wr_ok;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign wr_ok = push && !full;
    assign dout  = store[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            store[wr_ptr[AW-1:0]] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop && !empty) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rmii_rx_pacer.sv
module rmii_rx_pacer #(
    parameter int RATIO = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic speed_10,
    output logic tick,
    output logic slow
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            slow  <= 1'b0;
        end else begin
            if (idle) begin
                slow <= speed_10;
            end
            if (idle || div_q == LAST) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign tick = idle || !slow || (div_q == LAST);

endmodule

// File: rtl/rmii_rx_fsm.sv
module rmii_rx_fsm
    import rmii_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx_crs,
    input  logic     flag,
    input  logic     empty,
    input  nib_t     head,
    output logic     pop,
    output logic     idle,
    output logic     ph,
    output logic     err,
    output pin_out_t pins
);
    rx_state_e state_q, state_d;
    logic      ph_d, err_d, go_idle;
    pin_out_t  pins_d;

    always_comb begin
        state_d = state_q;
        ph_d    = ph;
        pins_d  = pins;
        pop     = 1'b0;
        go_idle = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    pins_d = PINS_REST;
                    if (rx_crs) begin
                        state_d = ST_LIVE;
                        ph_d    = 1'b0;
                        pins_d  = '{crs_dv: 1'b1, rxd: DB_QUIET};
                    end
                end
                ST_LIVE: begin
                    if (ph) begin
                        pins_d = '{crs_dv: 1'b1, rxd: err ? DB_BAD : nib_half(head, 1'b1)};
                        pop    = 1'b1;
                        ph_d   = 1'b0;
                    end else if (!empty) begin
                        pins_d = '{crs_dv: rx_crs, rxd: err ? DB_BAD : nib_half(head, 1'b0)};
                        ph_d   = 1'b1;
                    end else if (rx_crs) begin
                        pins_d = '{crs_dv: 1'b1, rxd: err ? DB_BAD : DB_QUIET};
                    end else begin
                        pins_d  = PINS_REST;
                        state_d = ST_IDLE;
                        go_idle = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
        err_d = go_idle ? 1'b0 : (err | (rx_crs & flag));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph      <= 1'b0;
            err     <= 1'b0;
            pins    <= PINS_REST;
        end else begin
            state_q <= state_d;
            ph      <= ph_d;
            err     <= err_d;
            pins    <= pins_d;
        end
    end

    assign idle = (state_q == ST_IDLE);

endmodule

// File: rtl/rmii_rx_formatter.sv
module rmii_rx_formatter
    import rmii_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int SLOW_RATIO = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       speed_10,
    input  logic       rx_crs,
    input  logic       rx_dv,
    input  logic [3:0] rx_nib,
    input  logic       rx_false,
    input  logic       rx_err,
    output logic       crs_dv,
    output logic [1:0] rxd
);
    logic     tick, slow, st_idle, ph_q, err_q;
    logic     fifo_pop, fifo_empty, fifo_full;
    nib_t     fifo_head;
    pin_out_t pins;

    rmii_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_dv),
        .pop   (fifo_pop),
        .din   (rx_nib),
        .dout  (fifo_head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    rmii_rx_pacer #(.RATIO(SLOW_RATIO)) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .idle     (st_idle),
        .speed_10 (speed_10),
        .tick     (tick),
        .slow     (slow)
    );

    rmii_rx_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .rx_crs (rx_crs),
        .flag   (rx_false | rx_err),
        .empty  (fifo_empty),
        .head   (fifo_head),
        .pop    (fifo_pop),
        .idle   (st_idle),
        .ph     (ph_q),
        .err    (err_q),
        .pins   (pins)
    );

    assign crs_dv = pins.crs_dv;
    assign rxd    = pins.rxd;

endmodule

// File: rtl/rmii_rx_formatter_chk.sv
module rmii_rx_formatter_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       slow,
    input logic       st_idle,
    input logic       ph_q,
    input logic       err_q,
    input logic       fifo_empty,
    input logic       fifo_full,
    input logic       rx_dv,
    input logic       rx_crs,
    input logic       crs_dv,
    input logic [1:0] rxd
);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        st_idle |-> (!crs_dv && rxd == 2'b00));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(crs_dv) && $stable(rxd)));

    p_bad_code_r6: assert property (@(posedge clk) disable iff (rst)
        (!st_idle && tick && err_q && !(!ph_q && fifo_empty && !rx_crs)) |=> (rxd == 2'b10));

    p_second_high_r8: assert property (@(posedge clk) disable iff (rst)
        (!st_idle && tick && ph_q) |=> crs_dv);

    p_first_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!st_idle && tick && !ph_q && !fifo_empty && !rx_crs) |=> !crs_dv);

    p_speed_locked_r10: assert property (@(posedge clk) disable iff (rst)
        !st_idle |=> $stable(slow));

    p_full_keeps_r11: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && rx_dv && !(!st_idle && tick && ph_q)) |=> fifo_full);

endmodule

bind rmii_rx_formatter rmii_rx_formatter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .slow       (slow),
    .st_idle    (st_idle),
    .ph_q       (ph_q),
    .err_q      (err_q),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .rx_dv      (rx_dv),
    .rx_crs     (rx_crs),
    .crs_dv     (crs_dv),
    .rxd        (rxd)
);

// File: tb/tb_rmii_rx_formatter.sv
`timescale 1ns/1ps
module tb_rmii_rx_formatter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       speed_10 = 1'b0;
    logic       rx_crs = 1'b0;
    logic       rx_dv = 1'b0;
    logic [3:0] rx_nib = 4'h0;
    logic       rx_false = 1'b0;
    logic       rx_err = 1'b0;
    logic       crs_dv;
    logic [1:0] rxd;

    int    errs = 0;
    int    checks = 0;
    string tag = "R1 reset";

    always #10 clk = ~clk;

    rmii_rx_formatter dut (
        .clk(clk), .rst(rst), .speed_10(speed_10), .rx_crs(rx_crs),
        .rx_dv(rx_dv), .rx_nib(rx_nib), .rx_false(rx_false), .rx_err(rx_err),
        .crs_dv(crs_dv), .rxd(rxd)
    );

    // Reference model of the requirements, advanced on each rising edge.
    bit         m_idle = 1'b1;
    bit         m_ph = 1'b0;
    int         m_div = 0;
    bit         m_spd = 1'b0;
    bit         m_err = 1'b0;
    bit         m_crs = 1'b0;
    logic [1:0] m_rxd = 2'b00;
    logic [3:0] m_q[$];

    always @(posedge clk) begin : model
        bit tk, emp, gi, popit, nid, nph;
        logic [3:0] hd;
        int sz;
        if (rst) begin
            m_idle = 1; m_ph = 0; m_div = 0; m_spd = 0; m_err = 0;
            m_crs = 0; m_rxd = 2'b00; m_q.delete();
        end else begin
            tk = m_idle || !m_spd || (m_div == 9);
            emp = (m_q.size() == 0);
            hd = emp ? 4'h0 : m_q[0];
            gi = 0; popit = 0; nid = m_idle; nph = m_ph;
            if (tk) begin
                if (m_idle) begin
                    m_rxd = 2'b00;
                    m_crs = rx_crs;
                    if (rx_crs) begin nid = 0; nph = 0; end
                end else if (!m_ph) begin
                    if (!emp) begin
                        m_crs = rx_crs; m_rxd = m_err ? 2'b10 : hd[1:0]; nph = 1;
                    end else if (rx_crs) begin
                        m_crs = 1; m_rxd = m_err ? 2'b10 : 2'b00;
                    end else begin
                        gi = 1; nid = 1; m_crs = 0; m_rxd = 2'b00;
                    end
                end else begin
                    m_crs = 1; m_rxd = m_err ? 2'b10 : hd[3:2]; popit = 1; nph = 0;
                end
            end
            m_div = m_idle ? 0 : ((m_div == 9) ? 0 : m_div + 1);
            if (m_idle) m_spd = speed_10;
            m_err = gi ? 1'b0 : (m_err | (rx_crs & (rx_false | rx_err)));
            sz = m_q.size();
            if (popit) void'(m_q.pop_front());
            if (rx_dv && sz < 8) m_q.push_back(rx_nib);
            m_idle = nid; m_ph = nph;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(crs_dv == m_crs && rxd == m_rxd, "{crs_dv,rxd} vs model",
                  {crs_dv, rxd}, {m_crs, m_rxd});
        end
    end

    task automatic wait_idle();
        while (!m_idle || m_q.size() != 0) @(negedge clk);
        tag = "R9 return to idle";
        check(crs_dv == 1'b0 && rxd == 2'b00, "idle outputs", {crs_dv, rxd}, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_frame(input bit ten, input int n, input bit sym, input int err_at,
                             input bit flip, input string t);
        int np;
        np = ten ? 20 : 2;
        @(negedge clk) speed_10 = ten;
        @(negedge clk) rx_crs = 1'b1;
        @(negedge clk);
        tag = "R2 carrier rise";
        check(crs_dv == 1'b1 && rxd == 2'b00, "first cycle of carrier", {crs_dv, rxd}, 3'b100);
        tag = t;
        repeat ($urandom % 4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_nib = (i == 0) ? 4'h5 : 4'($urandom);
            rx_dv = 1'b1;
            rx_err = sym && (i == err_at);
            if (flip && i == 1) speed_10 = !ten;
            @(negedge clk);
            rx_dv = 1'b0; rx_err = 1'b0;
            if (i == n - 1) rx_crs = 1'b0;
            repeat (np - 1) @(negedge clk);
        end
        wait_idle();
    endtask

    task automatic run_false(input bit ten, input int len);
        @(negedge clk) speed_10 = ten;
        @(negedge clk) begin rx_crs = 1'b1; rx_false = 1'b1; end
        tag = "R7 false carrier";
        @(negedge clk) rx_false = 1'b0;
        repeat (len) @(negedge clk);
        check(crs_dv == 1'b1 && rxd == 2'b10, "level during false carrier", {crs_dv, rxd}, 3'b110);
        rx_crs = 1'b0;
        wait_idle();
    endtask

    task automatic run_overflow();
        @(negedge clk) speed_10 = 1'b1;
        @(negedge clk) rx_crs = 1'b1;
        tag = "R11 overflow";
        for (int i = 0; i < 12; i++) begin
            rx_nib = 4'(i + 3); rx_dv = 1'b1;
            @(negedge clk);
        end
        rx_dv = 1'b0; rx_crs = 1'b0;
        wait_idle();
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        tag = "R1 reset";
        check(crs_dv == 1'b0 && rxd == 2'b00, "outputs in reset", {crs_dv, rxd}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(crs_dv == 1'b0 && rxd == 2'b00, "outputs after reset", {crs_dv, rxd}, 0);

        run_frame(1'b0, 6, 1'b0, 0, 1'b0, "R3 R4 R8 frame 100M");
        run_frame(1'b1, 4, 1'b0, 0, 1'b0, "R5 R8 frame 10M");
        run_frame(1'b0, 8, 1'b1, 3, 1'b0, "R6 symbol error 100M");
        run_frame(1'b1, 5, 1'b1, 2, 1'b0, "R6 symbol error 10M");
        run_false(1'b0, 6);
        run_false(1'b1, 25);
        run_frame(1'b0, 6, 1'b0, 0, 1'b1, "R10 speed held 100M");
        run_frame(1'b1, 4, 1'b0, 0, 1'b1, "R10 speed held 10M");
        run_overflow();

        for (int k = 0; k < 24; k++) begin
            int kind, n;
            bit ten;
            kind = $urandom % 4;
            ten = 1'($urandom % 2);
            n = 3 + $urandom % 10;
            case (kind)
                0: run_frame(ten, n, 1'b0, 0, 1'b0, "R4 R5 random frame");
                1: run_frame(ten, n, 1'b1, $urandom % n, 1'b0, "R6 random symbol error");
                2: run_false(ten, 12 + $urandom % 20);
                default: run_frame(ten, n, 1'b0, 0, 1'b1, "R10 random speed flip");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog (all requirements): actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule